// File: doc/BRIEF.md
# ADC conversion scan controller

This block sequences an eight-input successive-approximation converter. A 32-bit control word, held outside the block, sets which inputs take part, how far the bus clock is divided to make the converter clock, the result width, whether the converter is powered, and how conversions are launched. The block makes a converter clock tick and picks the input to convert. It sends the converter a one-cycle start strobe with the channel number and bit count. It then waits for the converter's done pulse and passes the result on, tagged with its channel.

There are three ways to launch a conversion. A software write can launch a single conversion. An edge of one of five external trigger inputs can launch one; the edge polarity is selectable, and each input passes through a two-flop synchronizer and an edge detector. In burst mode the block scans continuously, from the lowest enabled input up to the highest and then back to the lowest. A request that arrives while a conversion is running is held and served after that conversion.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, conv_tick_o, conv_start_o, busy_o and res_valid_o are all 0.
- R2: While the power bit (control bit 21) is 1, conv_tick_o pulses once every max(D, MIN_DIV)+1 clocks. D is control bits 15:8. MIN_DIV is the smallest divider that keeps the converter clock at or below CONV_CLK_MAX_HZ (2 with the bench parameters). conv_tick_o stays 0 while bit 21 is 0.
- R3: conv_start_o is a one-cycle pulse. It comes in the cycle after a conv_tick_o pulse, and busy_o is 1 from that cycle until the cycle after the converter's done pulse.
- R4: At a start, conv_bits_o equals 10 minus control bits 19:17. The result width is therefore 3 to 10 bits, and the converter takes conv_bits_o+1 ticks.
- R5: With burst (bit 16) at 0, a write strobe (ctrl_wr_i) that carries start code 1 in bits 26:24 launches exactly one conversion. It converts the lowest channel set in the mask (bits 7:0). An empty mask launches nothing.
- R6: With burst at 0, a start code c from 2 to 6 launches one conversion on an edge of trig_i[c-2]. Bit 27 at 0 selects rising edges and at 1 selects falling edges. Edges of the other polarity, and edges on other trigger inputs, launch nothing.
- R7: With burst at 1, conversions repeat with no start request. Each one takes the lowest enabled channel above the previous one, and wraps to the lowest enabled channel. The start field and write strobes have no effect on this order. Clearing burst stops new launches.
- R8: With bit 21 at 0, no conversion starts. Clearing the bit during a conversion drops busy_o on the next edge and produces no result.
- R9: One cycle after a done pulse that ends a conversion, res_valid_o pulses for one cycle. res_chan_o then gives the converted channel and res_data_o the data that came with the done pulse.
- R10: A software or trigger request that arrives while a conversion is running, including in the cycle the conversion completes, is held. It launches exactly one further conversion after the running one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 32 | Current control word |
| ctrl_wr_i | input | 1 | Pulses in the cycle the control word is written |
| trig_i | input | N_TRIG | Asynchronous external trigger inputs |
| conv_tick_o | output | 1 | Converter clock tick |
| conv_start_o | output | 1 | Start strobe to the converter |
| conv_chan_o | output | CH_W | Channel to convert |
| conv_bits_o | output | BITS_W | Result width in bits |
| conv_done_i | input | 1 | Converter done pulse |
| conv_data_i | input | RES_W | Converter result |
| busy_o | output | 1 | A conversion is in progress |
| res_valid_o | output | 1 | Result valid pulse |
| res_chan_o | output | CH_W | Channel of the result |
| res_data_o | output | RES_W | Result data |

## Verification
The risky overlap is a new start request, here a trigger edge, that lands in the very cycle the running conversion reports done. The request must survive the busy-to-idle change and produce exactly one further start. To provoke it, the bench sweeps the re-arm edge over a range of offsets after a start, so that one offset falls on the done cycle. At every offset it expects exactly one more start. A second overlap is a software write during a burst scan. It must leave the scan order unchanged, and a model of the scan order checks every start.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  // control word field positions
  localparam int F_MASK   = 0;
  localparam int F_DIV    = 8;
  localparam int F_BURST  = 16;
  localparam int F_ACC    = 17;
  localparam int F_ACC_W  = 3;
  localparam int F_PWR    = 21;
  localparam int F_START  = 24;
  localparam int F_STRT_W = 3;
  localparam int F_EDGE   = 27;

  localparam logic [F_STRT_W-1:0] START_SW = 3'd1;
  localparam int START_EXT = 2;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int DIV_W   = 8,
  parameter int MIN_DIV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] MIN_L = DIV_W'(MIN_DIV);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim    = (div_i < MIN_L) ? MIN_L : div_i;
  assign tick_o = en_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!en_i)    cnt_q <= '0;
    else if (tick_o)   cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int N_TRIG = 5,
  parameter int TRIG_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic [TRIG_W-1:0] sel_i,
  input  logic              fall_i,
  input  logic              en_i,
  output logic              hit_o
);
  localparam int PAD = 2 ** TRIG_W;

  logic [N_TRIG-1:0] rise, fall;
  logic [PAD-1:0]    rise_pad, fall_pad;

  for (genvar g = 0; g < N_TRIG; g++) begin : g_sync
    logic [2:0] sh_q;  // [1:0] synchronizer, [2] previous
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[1:0], trig_i[g]};
    end
    assign rise[g] = sh_q[1] & ~sh_q[2];
    assign fall[g] = ~sh_q[1] & sh_q[2];
  end

  assign rise_pad = PAD'(rise);
  assign fall_pad = PAD'(fall);
  assign hit_o    = en_i && (fall_i ? fall_pad[sel_i] : rise_pad[sel_i]);
endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int N_CH = 8,
  parameter int CH_W = 3
) (
  input  logic [N_CH-1:0] mask_i,
  input  logic [CH_W-1:0] last_i,
  input  logic            burst_i,
  output logic [CH_W-1:0] chan_o,
  output logic            any_o
);
  logic [CH_W-1:0] low, up;
  logic            up_ok;

  always_comb begin
    low   = '0;
    up    = '0;
    up_ok = 1'b0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        low = CH_W'(i);
        if (i > int'(last_i)) begin
          up    = CH_W'(i);
          up_ok = 1'b1;
        end
      end
    end
  end

  assign any_o  = |mask_i;
  assign chan_o = (burst_i && up_ok) ? up : low;
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int N_CH            = 8,
  parameter int N_TRIG          = 5,
  parameter int DIV_W           = 8,
  parameter int RES_W           = 10,
  parameter int CLK_HZ          = 100_000_000,
  parameter int CONV_CLK_MAX_HZ = 4_500_000,
  parameter int CH_W            = $clog2(N_CH),
  parameter int BITS_W          = $clog2(RES_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       ctrl_i,
  input  logic              ctrl_wr_i,
  input  logic [N_TRIG-1:0] trig_i,
  output logic              conv_tick_o,
  output logic              conv_start_o,
  output logic [CH_W-1:0]   conv_chan_o,
  output logic [BITS_W-1:0] conv_bits_o,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_data_i,
  output logic              busy_o,
  output logic              res_valid_o,
  output logic [CH_W-1:0]   res_chan_o,
  output logic [RES_W-1:0]  res_data_o
);
  localparam int TRIG_W  = $clog2(N_TRIG);
  localparam int MIN_DIV = (CLK_HZ + CONV_CLK_MAX_HZ - 1) / CONV_CLK_MAX_HZ - 1;

  logic [N_CH-1:0]     mask;
  logic [DIV_W-1:0]    div;
  logic                burst, pwr, fall;
  logic [F_ACC_W-1:0]  acc;
  logic [F_STRT_W-1:0] start_code;
  logic                unused_ctrl;

  assign mask        = ctrl_i[F_MASK +: N_CH];
  assign div         = ctrl_i[F_DIV +: DIV_W];
  assign burst       = ctrl_i[F_BURST];
  assign acc         = ctrl_i[F_ACC +: F_ACC_W];
  assign pwr         = ctrl_i[F_PWR];
  assign start_code  = ctrl_i[F_START +: F_STRT_W];
  assign fall        = ctrl_i[F_EDGE];
  assign unused_ctrl = ^{ctrl_i[31:28], ctrl_i[23:22], ctrl_i[20]};

  logic              tick, trig_hit, sw_hit, ext_ok, any_ch, req, launch;
  logic [TRIG_W-1:0] trig_sel;
  logic [CH_W-1:0]   pick_chan;
  logic              pend_q, busy_q, start_q, res_valid_q;
  logic [CH_W-1:0]   chan_q, last_q, res_chan_q;
  logic [BITS_W-1:0] bits_q;
  logic [RES_W-1:0]  res_data_q;

  assign ext_ok   = (int'(start_code) >= START_EXT) && (int'(start_code) < START_EXT + N_TRIG);
  assign trig_sel = TRIG_W'(start_code - F_STRT_W'(START_EXT));

  adc_clk_div #(
    .DIV_W  (DIV_W),
    .MIN_DIV(MIN_DIV)
  ) u_clk_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (pwr),
    .div_i (div),
    .tick_o(tick)
  );

  adc_trig_sync #(
    .N_TRIG(N_TRIG),
    .TRIG_W(TRIG_W)
  ) u_trig_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(trig_i),
    .sel_i (trig_sel),
    .fall_i(fall),
    .en_i  (pwr && !burst && ext_ok),
    .hit_o (trig_hit)
  );

  adc_chan_pick #(
    .N_CH(N_CH),
    .CH_W(CH_W)
  ) u_chan_pick (
    .mask_i (mask),
    .last_i (last_q),
    .burst_i(burst),
    .chan_o (pick_chan),
    .any_o  (any_ch)
  );

  assign sw_hit = ctrl_wr_i && pwr && !burst && (start_code == START_SW);
  assign req    = burst || pend_q;
  assign launch = pwr && !busy_q && tick && req && any_ch;

  // request latch: a fresh hit wins over the launch that consumes the old one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      pend_q <= 1'b0;
    else if (!pwr || burst || !any_ch) pend_q <= 1'b0;
    else if (sw_hit || trig_hit)      pend_q <= 1'b1;
    else if (launch)                  pend_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          busy_q <= 1'b0;
    else if (!pwr)        busy_q <= 1'b0;
    else if (launch)      busy_q <= 1'b1;
    else if (conv_done_i) busy_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      chan_q  <= '0;
      bits_q  <= '0;
      last_q  <= CH_W'(N_CH - 1);
    end else begin
      start_q <= launch;
      if (launch) begin
        chan_q <= pick_chan;
        bits_q <= BITS_W'(RES_W) - BITS_W'(acc);
        last_q <= pick_chan;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_q <= 1'b0;
      res_chan_q  <= '0;
      res_data_q  <= '0;
    end else begin
      res_valid_q <= pwr && busy_q && conv_done_i;
      if (pwr && busy_q && conv_done_i) begin
        res_chan_q <= chan_q;
        res_data_q <= conv_data_i;
      end
    end
  end

  assign conv_tick_o  = tick;
  assign conv_start_o = start_q;
  assign conv_chan_o  = chan_q;
  assign conv_bits_o  = bits_q;
  assign busy_o       = busy_q;
  assign res_valid_o  = res_valid_q;
  assign res_chan_o   = res_chan_q;
  assign res_data_o   = res_data_q;
endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk
  import adc_scan_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int RES_W  = 10,
  parameter int CH_W   = 3,
  parameter int BITS_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [31:0]       ctrl_i,
  input logic              conv_tick_o,
  input logic              conv_start_o,
  input logic [CH_W-1:0]   conv_chan_o,
  input logic [BITS_W-1:0] conv_bits_o,
  input logic              conv_done_i,
  input logic              busy_o,
  input logic              res_valid_o
);
  logic [N_CH-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= ctrl_i[F_MASK +: N_CH];
  end

  p_start_after_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> $past(conv_tick_o));
  p_start_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);
  p_start_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> busy_o);
  p_bits_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> (conv_bits_o >= BITS_W'(3) && conv_bits_o <= BITS_W'(RES_W)));
  p_chan_enabled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> mask_q[conv_chan_o]);
  p_start_powered_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> $past(ctrl_i[F_PWR]));
  p_idle_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!ctrl_i[F_PWR]) |-> !busy_o);
  p_result_after_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(conv_done_i && busy_o));
endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk #(
  .N_CH  (N_CH),
  .RES_W (RES_W),
  .CH_W  (CH_W),
  .BITS_W(BITS_W)
) i_adc_scan_ctrl_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_i      (ctrl_i),
  .conv_tick_o (conv_tick_o),
  .conv_start_o(conv_start_o),
  .conv_chan_o (conv_chan_o),
  .conv_bits_o (conv_bits_o),
  .conv_done_i (conv_done_i),
  .busy_o      (busy_o),
  .res_valid_o (res_valid_o)
);

// File: tb/test_adc_scan_ctrl.sv
module test_adc_scan_ctrl;
  localparam int N_CH = 8, N_TRIG = 5, DIV_W = 8, RES_W = 10;
  localparam int CLK_HZ = 10_000_000, CONV_MAX = 4_500_000;
  localparam int MIN_DIV = (CLK_HZ + CONV_MAX - 1) / CONV_MAX - 1;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] ctrl = '0;
  logic        wr = 1'b0;
  logic [4:0]  trig = '0;
  logic        tick, start, busy, res_valid;
  logic [2:0]  chan, res_chan;
  logic [3:0]  bits;
  logic        done;
  logic [9:0]  data, res_data;

  always #5 clk = ~clk;

  adc_scan_ctrl #(
    .N_CH(N_CH), .N_TRIG(N_TRIG), .DIV_W(DIV_W), .RES_W(RES_W),
    .CLK_HZ(CLK_HZ), .CONV_CLK_MAX_HZ(CONV_MAX)
  ) i_adc_scan_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .ctrl_wr_i(wr), .trig_i(trig),
    .conv_tick_o(tick), .conv_start_o(start), .conv_chan_o(chan), .conv_bits_o(bits),
    .conv_done_i(done), .conv_data_i(data), .busy_o(busy),
    .res_valid_o(res_valid), .res_chan_o(res_chan), .res_data_o(res_data)
  );

  int n_chk = 0, n_fail = 0, n_start = 0, n_res = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] m, input logic [7:0] d, input bit b,
                                     input logic [2:0] a, input bit p, input logic [2:0] s,
                                     input bit f);
    logic [31:0] w;
    w = '0;
    w[7:0] = m; w[15:8] = d; w[16] = b; w[19:17] = a; w[21] = p; w[26:24] = s; w[27] = f;
    return w;
  endfunction

  function automatic int exp_pick(input logic [7:0] m, input int last, input bit b);
    int lo, up;
    lo = -1; up = -1;
    for (int i = 0; i < 8; i++)
      if (m[i]) begin
        if (lo < 0) lo = i;
        if (b && up < 0 && i > last) up = i;
      end
    return (up >= 0) ? up : lo;
  endfunction

  function automatic int exp_period(input logic [7:0] d);
    return ((int'(d) < MIN_DIV) ? MIN_DIV : int'(d)) + 1;
  endfunction

  // converter model: bits+1 ticks after start, then a done pulse with data
  bit mdl_busy;
  int mdl_left;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdl_busy <= 1'b0; mdl_left <= 0; done <= 1'b0; data <= '0;
    end else begin
      done <= 1'b0;
      if (!ctrl[21]) mdl_busy <= 1'b0;
      else if (start) begin
        mdl_busy <= 1'b1; mdl_left <= int'(bits) + 1;
      end else if (mdl_busy && tick) begin
        if (mdl_left == 1) begin
          done <= 1'b1; data <= 10'($urandom); mdl_busy <= 1'b0;
        end else mdl_left <= mdl_left - 1;
      end
    end
  end

  // monitor
  logic [31:0] ctrl_prev = '0;
  bit tick_prev = 0, gap_ok = 0, pend_res = 0;
  int since = 0, exp_last = 7, cur_chan = 0, exp_c = 0;
  logic [9:0] exp_d = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (start) begin
        int e;
        e = exp_pick(ctrl_prev[7:0], exp_last, ctrl_prev[16]);
        chk(int'(chan) == e, "R5 R7 channel", int'(chan), e);
        chk(int'(bits) == 10 - int'(ctrl_prev[19:17]), "R4 bits", int'(bits),
            10 - int'(ctrl_prev[19:17]));
        chk(tick_prev, "R3 start after tick", 0, 1);
        chk(busy, "R3 busy at start", 0, 1);
        exp_last = int'(chan); cur_chan = int'(chan); n_start++;
      end
      if (pend_res) begin
        chk(res_valid && int'(res_chan) == exp_c && res_data == exp_d, "R9 result",
            int'(res_data), int'(exp_d));
        pend_res = 0; n_res++;
      end else if (res_valid) chk(0, "R9 spurious result", 1, 0);
      if (done && busy) begin
        pend_res = 1; exp_d = data; exp_c = cur_chan;
      end
      if (!ctrl[21] || ctrl[15:8] != ctrl_prev[15:8] || !ctrl_prev[21]) gap_ok = 0;
      if (!ctrl[21]) chk(!tick, "R2 no tick while off", 1, 0);
      since++;
      if (tick) begin
        if (gap_ok) chk(since == exp_period(ctrl[15:8]), "R2 tick period", since,
                        exp_period(ctrl[15:8]));
        since = 0; gap_ok = 1;
      end
    end
    ctrl_prev = ctrl;
    tick_prev = tick;
  end

  task automatic wr_ctrl(input logic [31:0] w, input bit s);
    @(posedge clk); #1;
    ctrl = w; wr = s;
    if (s) begin @(posedge clk); #1; wr = 1'b0; end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic set_trig(input int idx, input bit v);
    @(posedge clk); #1;
    trig[idx] = v;
  endtask

  task automatic wait_start(input int max, output bit got);
    int s0;
    s0 = n_start; got = 0;
    for (int i = 0; i < max && !got; i++) begin
      @(negedge clk); #1;
      if (n_start != s0) got = 1;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int s0, r0;
    bit got;
    void'($urandom(32'h5eed));
    // R1
    repeat (3) @(negedge clk);
    chk(!tick && !start && !busy && !res_valid, "R1 reset state",
        int'({tick, start, busy, res_valid}), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    cycles(3);
    chk(!start && !busy && !res_valid, "R1 after release", int'({start, busy, res_valid}), 0);

    // R2: divider incl. clamp
    for (int k = 0; k < 6; k++) begin
      logic [7:0] d;
      d = (k < 2) ? 8'(k) : 8'($urandom_range(2, 9));
      wr_ctrl(mk(8'h00, d, 0, 3'd0, 1, 3'd0, 0), 0);
      cycles(40);
    end
    wr_ctrl(mk(8'h00, 8'd0, 0, 3'd0, 1, 3'd0, 0), 0);
    cycles(5);
    begin
      int nt;
      nt = 0;
      repeat (30) begin @(negedge clk); if (tick) nt++; end
      chk(nt == 10, "R2 clamped period", nt, 10);
    end

    // R8: powered down, software write launches nothing
    wr_ctrl(mk(8'hFF, 8'd1, 0, 3'd0, 0, 3'd1, 0), 1);
    s0 = n_start; cycles(60);
    chk(n_start == s0, "R8 no start while off", n_start - s0, 0);

    // R5: software start, random masks and widths
    for (int k = 0; k < 6; k++) begin
      logic [7:0] m;
      m = (k == 0) ? 8'h80 : 8'($urandom_range(1, 255));
      s0 = n_start; r0 = n_res;
      wr_ctrl(mk(m, 8'($urandom_range(0, 4)), 0, 3'($urandom_range(0, 7)), 1, 3'd1, 0), 1);
      cycles(150);
      chk(n_start - s0 == 1, "R5 one start per write", n_start - s0, 1);
      chk(n_res - r0 == 1, "R9 one result", n_res - r0, 1);
    end
    s0 = n_start;
    wr_ctrl(mk(8'h00, 8'd1, 0, 3'd2, 1, 3'd1, 0), 1);
    cycles(100);
    chk(n_start == s0, "R5 empty mask", n_start - s0, 0);

    // R6: external triggers
    for (int k = 0; k < 5; k++) begin
      bit f;
      int j;
      f = 1'($urandom); j = (k + 1) % 5;
      wr_ctrl(mk(8'($urandom_range(1, 255)), 8'($urandom_range(0, 3)), 0,
                 3'($urandom_range(0, 7)), 1, 3'(2 + k), f), 0);
      cycles(5);
      s0 = n_start;
      set_trig(j, 1); cycles(5); set_trig(j, 0);
      cycles(40);
      chk(n_start == s0, "R6 other input ignored", n_start - s0, 0);
      if (f) begin
        set_trig(k, 1); cycles(60);
        chk(n_start == s0, "R6 rising ignored when falling chosen", n_start - s0, 0);
        set_trig(k, 0); wait_start(150, got);
        chk(got, "R6 falling edge start", 0, 1);
        cycles(150);
      end else begin
        set_trig(k, 1); wait_start(150, got);
        chk(got, "R6 rising edge start", 0, 1);
        cycles(150);
        s0 = n_start;
        set_trig(k, 0); cycles(60);
        chk(n_start == s0, "R6 falling ignored when rising chosen", n_start - s0, 0);
      end
      trig = '0;
    end

    // R10: software request while busy
    s0 = n_start;
    wr_ctrl(mk(8'h24, 8'd1, 0, 3'd0, 1, 3'd1, 0), 1);
    cycles(8);
    wr_ctrl(mk(8'h24, 8'd1, 0, 3'd0, 1, 3'd1, 0), 1);
    cycles(300);
    chk(n_start - s0 == 2, "R10 held software request", n_start - s0, 2);

    // R10: trigger edge swept across the conversion, including the done cycle
    wr_ctrl(mk(8'h01, 8'd0, 0, 3'd7, 1, 3'd2, 0), 0);
    for (int off = 0; off < 20; off++) begin
      trig[0] = 1'b0; cycles(4);
      set_trig(0, 1); wait_start(40, got);
      chk(got, "R10 first start", 0, 1);
      cycles(off);
      set_trig(0, 0); cycles(2);
      s0 = n_start;
      set_trig(0, 1); cycles(80);
      chk(n_start - s0 == 1, "R10 edge at offset", n_start - s0, 1);
    end
    trig = '0;
    cycles(20);

    // R7: burst scan, start field and writes ignored
    for (int k = 0; k < 3; k++) begin
      logic [7:0] m;
      logic [31:0] w;
      int pop;
      m = (k == 0) ? 8'h81 : (k == 1) ? 8'hFF : 8'($urandom_range(1, 255));
      pop = $countones(m);
      w = mk(m, 8'($urandom_range(0, 3)), 1, 3'($urandom_range(3, 7)), 1,
             3'($urandom_range(1, 7)), 1'($urandom));
      wr_ctrl(w, 0);
      for (int i = 0; i < pop; i++) begin
        wait_start(200, got); chk(got, "R7 burst start", 0, 1);
      end
      wr_ctrl(w, 1);
      for (int i = 0; i < pop; i++) begin
        wait_start(200, got); chk(got, "R7 burst after write", 0, 1);
      end
      w[16] = 1'b0; w[26:24] = 3'd0;
      wr_ctrl(w, 0);
      s0 = n_start; cycles(150);
      chk(n_start == s0, "R7 burst off stops", n_start - s0, 0);
      chk(!busy, "R7 idle after stop", int'(busy), 0);
    end

    // R8: power drop during a conversion
    wr_ctrl(mk(8'hFF, 8'd2, 1, 3'd0, 1, 3'd0, 0), 0);
    wait_start(200, got);
    cycles(2);
    r0 = n_res;
    wr_ctrl(mk(8'hFF, 8'd2, 1, 3'd0, 0, 3'd0, 0), 0);
    cycles(2);
    chk(!busy, "R8 abort clears busy", int'(busy), 0);
    s0 = n_start; cycles(80);
    chk(n_start == s0, "R8 no start after abort", n_start - s0, 0);
    chk(n_res == r0, "R8 no result after abort", n_res - r0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule